// File: doc/BRIEF.md
# Mode-Switchable Split Accumulator

This block holds a 16-bit working register for a datapath that can run either at byte width or at word width. A narrow-mode input and a byte-select input together decide the effective width. At word width the register behaves as a single 16-bit value. At byte width only the low byte takes part in operations, and the high byte is kept untouched as spare storage.

Results from the arithmetic unit arrive on a 16-bit bus and are written when a write strobe is high. The block returns the full stored value together with an operand at the effective width, zero-extended to 16 bits. A byte-swap strobe exchanges the two halves. The swap works the same way at either width, which is how the hidden high byte is brought back into use.

Top module: `split_acc`

## Requirements
- R1: While reset is high, both bytes are cleared, so `acc_full` reads 0x0000 on the first cycle after reset.
- R2: The register is at word width only when `narrow_mode` is 0 and `byte_sel` is 0. In every other combination it is at byte width. `narrow_mode` = 1 forces byte width whatever `byte_sel` says.
- R3: At word width, a write (`wr_en` = 1, `swap_en` = 0) stores all 16 bits of `wr_data` at the next rising edge.
- R4: At byte width, a write stores `wr_data[7:0]` into the low byte and leaves the high byte unchanged. `wr_data[15:8]` has no effect.
- R5: A swap (`swap_en` = 1) exchanges the low byte (bits 7:0) and the high byte (bits 15:8) at the next rising edge, at either width.
- R6: When `swap_en` and `wr_en` are both 1 in the same cycle, only the swap is performed and `wr_data` is ignored.
- R7: `operand` equals `acc_full` at word width. At byte width it equals `{8'h00, acc_full[7:0]}`. It follows width changes combinationally.
- R8: With neither strobe high, the stored value holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_mode | input | 1 | 1 forces byte width |
| byte_sel | input | 1 | 1 selects byte width when narrow_mode is 0 |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 16 | Result bus from the arithmetic unit |
| swap_en | input | 1 | Exchange the low and high bytes |
| acc_full | output | 16 | Full stored value |
| operand | output | 16 | Operand at the effective width, zero-extended |

## Verification
A write and a swap can be requested in the same cycle. The bench provokes this by raising both strobes together, at both widths and with write data unlike either stored byte. The reference model swaps its stored bytes and drops the write data, and it is compared every cycle against `acc_full` and `operand`. A width change in the cycle just before the collision also shows that the swap ignores the width, while a lone write honours it.

// File: rtl/split_acc_pkg.sv
package split_acc_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2
  } acc_op_e;

  function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
    return {v[BYTE_W-1:0], v[WORD_W-1:BYTE_W]};
  endfunction

  function automatic logic [WORD_W-1:0] merge_write(input logic [WORD_W-1:0] cur,
                                                    input logic [WORD_W-1:0] din,
                                                    input logic narrow);
    return narrow ? {cur[WORD_W-1:BYTE_W], din[BYTE_W-1:0]} : din;
  endfunction

  function automatic logic [WORD_W-1:0] zext_low(input logic [WORD_W-1:0] v,
                                                 input logic narrow);
    return narrow ? {{BYTE_W{1'b0}}, v[BYTE_W-1:0]} : v;
  endfunction
endpackage

// File: rtl/acc_width_ctl.sv
module acc_width_ctl
  import split_acc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    narrow_mode,
  input  logic    byte_sel,
  input  logic    wr_en,
  input  logic    swap_en,
  output logic    is_narrow,
  output acc_op_e op
);
  assign is_narrow = narrow_mode | byte_sel;

  always_comb begin
    if (swap_en)    op = OP_SWAP;
    else if (wr_en) op = OP_WRITE;
    else            op = OP_HOLD;
  end

  // R2
  narrow_force_chk: assert property (@(posedge clk) disable iff (rst)
    narrow_mode |-> is_narrow);
  // R6
  swap_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (swap_en && wr_en) |-> (op == OP_SWAP));
endmodule

// File: rtl/acc_storage.sv
module acc_storage
  import split_acc_pkg::*;
#(
  parameter int BW = BYTE_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic [BW-1:0] lo_d,
  input  logic [BW-1:0] hi_d,
  output logic [BW-1:0] lo_q,
  output logic [BW-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= lo_d;
      if (hi_we) hi_q <= hi_d;
    end
  end

  // R8
  lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_we |=> $stable(lo_q));
  // R4
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hi_we |=> $stable(hi_q));
endmodule

// File: rtl/split_acc.sv
module split_acc
  import split_acc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              narrow_mode,
  input  logic              byte_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              swap_en,
  output logic [WORD_W-1:0] acc_full,
  output logic [WORD_W-1:0] operand
);
  logic              is_narrow;
  acc_op_e           op;
  logic [WORD_W-1:0] next_val;
  logic              lo_we, hi_we;
  logic [BYTE_W-1:0] lo_q, hi_q;

  acc_width_ctl u_ctl (
    .clk(clk), .rst(rst), .narrow_mode(narrow_mode), .byte_sel(byte_sel),
    .wr_en(wr_en), .swap_en(swap_en), .is_narrow(is_narrow), .op(op)
  );

  always_comb begin
    unique case (op)
      OP_SWAP:  next_val = swap_bytes(acc_full);
      OP_WRITE: next_val = merge_write(acc_full, wr_data, is_narrow);
      default:  next_val = acc_full;
    endcase
  end

  assign lo_we = (op != OP_HOLD);
  assign hi_we = (op == OP_SWAP) || (op == OP_WRITE && !is_narrow);

  acc_storage #(.BW(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .lo_we(lo_we), .hi_we(hi_we),
    .lo_d(next_val[BYTE_W-1:0]), .hi_d(next_val[WORD_W-1:BYTE_W]),
    .lo_q(lo_q), .hi_q(hi_q)
  );

  assign acc_full = {hi_q, lo_q};
  assign operand  = zext_low(acc_full, is_narrow);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (acc_full == '0));
  // R5
  swap_exch_chk: assert property (@(posedge clk) disable iff (rst)
    swap_en |=> (acc_full == {$past(acc_full[BYTE_W-1:0]), $past(acc_full[WORD_W-1:BYTE_W])}));
  // R3
  wide_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !swap_en && !narrow_mode && !byte_sel) |=> (acc_full == $past(wr_data)));
  // R4
  narrow_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !swap_en && (narrow_mode || byte_sel)) |=>
      (acc_full == {$past(acc_full[WORD_W-1:BYTE_W]), $past(wr_data[BYTE_W-1:0])}));
  // R7
  always_comb begin
    if (!rst) begin
      operand_width_chk: assert ((narrow_mode || byte_sel) ?
        (operand[WORD_W-1:BYTE_W] == '0 && operand[BYTE_W-1:0] == acc_full[BYTE_W-1:0]) :
        (operand == acc_full));
    end
  end
endmodule

// File: tb/sim_split_acc.sv
module sim_split_acc;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic narrow_mode = 0, byte_sel = 0, wr_en = 0, swap_en = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] acc_full, operand;

  int checks = 0, failures = 0;
  int unsigned mdl = 0;
  bit done = 0;

  split_acc u0 (.clk(clk), .rst(rst), .narrow_mode(narrow_mode), .byte_sel(byte_sel),
    .wr_en(wr_en), .wr_data(wr_data), .swap_en(swap_en),
    .acc_full(acc_full), .operand(operand));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: integer arithmetic on bytes.
  always @(posedge clk) begin
    int lo, hi;
    lo = mdl % 256; hi = mdl / 256;
    if (rst) mdl = 0;
    else if (swap_en) mdl = lo * 256 + hi;
    else if (wr_en) begin
      if (narrow_mode == 1 || byte_sel == 1) mdl = hi * 256 + (wr_data % 256);
      else mdl = wr_data;
    end
  end

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the edge.
  always @(negedge clk) if (!rst && !done) begin
    int unsigned opexp;
    opexp = (narrow_mode || byte_sel) ? (mdl % 256) : mdl;
    chk("R3/R4/R5/R6/R8 acc_full", acc_full, mdl);
    chk("R2/R7 operand", operand, opexp);
  end

  task automatic step(input bit n, input bit b, input bit w, input bit s, input logic [15:0] d);
    @(negedge clk);
    narrow_mode = n; byte_sel = b; wr_en = w; swap_en = s; wr_data = d;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1 chk("R1 reset value", acc_full, 16'h0000);
    step(0,0,1,0,16'hA1B2);                 // R3 wide write
    step(0,0,0,0,16'hFFFF);                 // R8 hold
    step(0,1,1,0,16'h5C3D);                 // R4 narrow via byte_sel
    step(1,0,1,0,16'h7E44);                 // R2 forced narrow
    step(1,1,0,0,0);
    step(0,0,0,1,0);                        // R5 swap wide
    step(0,1,0,1,0);                        // R5 swap narrow
    step(0,0,1,1,16'h9999);                 // R6 collision wide
    step(1,0,1,1,16'h1234);                 // R6 collision narrow
    step(0,0,1,0,16'hFFFF);
    step(0,1,1,0,16'h0000);                 // R4 boundary
    step(0,1,0,1,0);
    step(0,0,0,0,0);                        // R7 width flip
    step(1,1,0,0,0);
    for (int i = 0; i < 200; i++)
      step($urandom%2, $urandom%2, $urandom%2, ($urandom%4)==0, 16'($urandom));
    step(0,0,0,0,0);
    rst = 1;
    @(negedge clk); rst = 0;
    #1 chk("R1 reset after use", acc_full, 16'h0000);
    @(negedge clk); done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule